// File: doc/BRIEF.md
# Storage-Card Clock Generator with Oscillator Fallback

This block makes two storage-card clocks, one for an embedded MMC device and one for a removable SD card. Each channel divides a selected source by an integer and then halves the result, so its output always has a 50% duty cycle. The source is either the general PLL or the 24 MHz crystal oscillator. Both sources enter as clock-enable tick strobes in the `clk` domain. The source select is therefore synchronous, and it changes only at an output cycle boundary.

A small configuration engine takes a request: an operation, a clock identifier, the current general PLL rate in Hz and, for a set, the wanted frequency in Hz. For a set, the engine first finds the smallest divider that keeps the output at or below the request, measured against the PLL. If no divider up to 128 is enough, the engine switches that channel to the oscillator and searches again. It then programs the channel and divides the rate back out of the stored fields. The reported rate is therefore the rate the channel will really produce, not the rate that was asked for. A get reports the rate of the stored settings and changes nothing.

The engine FSM has these states: ST_IDLE, ST_SEARCH, ST_APPLY, ST_FETCH, ST_DIVIDE, ST_REPORT and ST_REJECT. Its transitions are as follows.
- ST_IDLE moves to ST_REJECT on a bad request, to ST_SEARCH on a valid set, and to ST_FETCH on a get.
- ST_SEARCH stays in ST_SEARCH while stepping. It also stays there on the one fallback step that switches to the oscillator. It moves to ST_APPLY when a divider is found or the clamp is hit.
- ST_APPLY moves to ST_FETCH.
- ST_FETCH moves to ST_DIVIDE.
- ST_DIVIDE moves to ST_REPORT when the serial divider finishes.
- ST_REPORT and ST_REJECT both return to ST_IDLE.

Top module: `mmc_clkgen`

## Requirements
- R1: cfg_id values 0 and 1 address the eMMC channel, and 2 and 3 address the SD channel. Both identifiers of a channel reach the same settings. Values 4 to 7 are rejected.
- R2: A set (cfg_op=0) computes d = max(1, ceil((gpll_hz/2)/req_hz)). When d ≤ 128, the set selects the general PLL source and stores divider field d-1.
- R3: When d > 128, the set selects the oscillator and recomputes d = ceil(12 000 000/req_hz). It clamps d to 128 and stores d-1.
- R4: A channel output has high and low phases of exactly (field+1) ticks of its selected source each, for a period of 2·(field+1) ticks.
- R5: A completed request reports rate_hz = floor(src/(2·(field+1))), computed from the stored fields. src is 24 000 000 for the oscillator, or the gpll_hz given with the request for the PLL.
- R6: A get (cfg_op=1) reports the rate of the addressed channel's stored settings and leaves them unchanged.
- R7: A set with req_hz=0 or any request with an invalid identifier pulses cfg_err for one cycle. No cfg_done follows, and no setting changes.
- R8: New settings take effect only at the next rising edge of the channel output. The phase in progress finishes with the old settings.
- R9: Programming one channel never alters the other channel's settings or output.
- R10: After reset, both channels select the oscillator with field 0, and cfg_busy, cfg_done and cfg_err are low.
- R11: cfg_start is accepted only while cfg_busy is low. cfg_busy is high from the cycle after acceptance until the result cycle. Each accepted request ends in exactly one cycle with either cfg_done or cfg_err high, never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gpll_tick | input | 1 | One strobe per general PLL source cycle |
| osc_tick | input | 1 | One strobe per oscillator source cycle |
| cfg_start | input | 1 | Request strobe |
| cfg_op | input | 1 | 0 = set rate, 1 = get rate |
| cfg_id | input | 3 | Clock identifier (R1) |
| gpll_hz | input | 32 | Current general PLL rate in Hz |
| req_hz | input | 32 | Requested frequency in Hz (set only) |
| cfg_busy | output | 1 | Request in progress |
| cfg_done | output | 1 | One-cycle success pulse, rate_hz valid |
| cfg_err | output | 1 | One-cycle rejection pulse |
| rate_hz | output | 32 | Achieved rate of the last completed request |
| emmc_clk | output | 1 | eMMC channel clock |
| sd_clk | output | 1 | SD channel clock |

## Verification
The hardest case to reach from the ports is a reprogram that lands in the middle of a long output period. It is the only case that shows whether the change waits for the boundary. The bench first sets a divider of 128, which gives a 256-cycle period. It waits for a rising edge and then at once issues a set that completes long before that period ends. It then requires the old 256-cycle period to finish, followed by the new short one. The clamped oscillator path is also hard to reach. It needs requests below about 94 kHz, so the sweep includes 1 Hz and 50 kHz requests, and a start pulse is injected during the longest search to confirm it is ignored.

// File: rtl/mmc_clk_pkg.sv
package mmc_clk_pkg;
    localparam int CHANS   = 2;
    localparam int ID_W    = 3;
    localparam int FIELD_W = 7;
    localparam int RATE_W  = 32;
    localparam int MAXDIV  = 1 << FIELD_W;
    localparam int DEN_W   = FIELD_W + 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEARCH,
        ST_APPLY,
        ST_FETCH,
        ST_DIVIDE,
        ST_REPORT,
        ST_REJECT
    } cfg_state_e;

    typedef enum logic {
        SRC_GPLL = 1'b0,
        SRC_OSC  = 1'b1
    } src_sel_e;

    typedef enum logic {
        OP_SET = 1'b0,
        OP_GET = 1'b1
    } cfg_op_e;
endpackage

// File: rtl/mmc_long_div.sv
module mmc_long_div
    import mmc_clk_pkg::*;
#(
    parameter int NUM_W = RATE_W,
    parameter int DW    = DEN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DW-1:0]    den,
    output logic             done,
    output logic [NUM_W-1:0] quot
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] sh_q;
    logic [DW-1:0]    rem_q;
    logic [DW-1:0]    den_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             done_q;
    logic [DW:0]      rem_sh;
    logic             fits;

    assign rem_sh = {rem_q, sh_q[NUM_W-1]};
    assign fits   = rem_sh >= {1'b0, den_q};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            rem_q  <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                sh_q   <= num;
                rem_q  <= '0;
                den_q  <= den;
                cnt_q  <= CNT_W'(NUM_W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                sh_q  <= {sh_q[NUM_W-2:0], fits};
                rem_q <= fits ? DW'(rem_sh - {1'b0, den_q}) : DW'(rem_sh);
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done = done_q;
    assign quot = sh_q;

    AST_REM_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (rem_q < den_q)); // R5
endmodule

// File: rtl/mmc_clk_chan.sv
module mmc_clk_chan
    import mmc_clk_pkg::*;
#(
    parameter int FW = FIELD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gpll_tick,
    input  logic          osc_tick,
    input  logic          wr,
    input  logic          wr_sel,
    input  logic [FW-1:0] wr_field,
    output logic          prog_sel,
    output logic [FW-1:0] prog_field,
    output logic          clk_out
);
    src_sel_e      cur_sel_q, pend_sel_q;
    logic [FW-1:0] cur_field_q, pend_field_q;
    logic          pend_q;
    logic [FW-1:0] cnt_q;
    logic          out_q;
    logic          tick;
    logic          terminal;

    assign tick     = (cur_sel_q == SRC_OSC) ? osc_tick : gpll_tick;
    assign terminal = tick && (cnt_q == cur_field_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_sel_q    <= SRC_OSC;
            cur_field_q  <= '0;
            pend_sel_q   <= SRC_OSC;
            pend_field_q <= '0;
            pend_q       <= 1'b0;
            cnt_q        <= '0;
            out_q        <= 1'b0;
        end else begin
            if (terminal) begin
                cnt_q <= '0;
                out_q <= ~out_q;
            end else if (tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (terminal && !out_q && pend_q) begin
                cur_sel_q   <= pend_sel_q;
                cur_field_q <= pend_field_q;
            end
            if (wr) begin
                pend_sel_q   <= src_sel_e'(wr_sel);
                pend_field_q <= wr_field;
                pend_q       <= 1'b1;
            end else if (terminal && !out_q) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign prog_sel   = pend_q ? pend_sel_q : cur_sel_q;
    assign prog_field = pend_q ? pend_field_q : cur_field_q;
    assign clk_out    = out_q;

    AST_SWITCH_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cur_field_q) || !$stable(cur_sel_q)) |-> $rose(out_q)); // R8
    AST_TOGGLE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_q) |-> $past(tick)); // R4
endmodule

// File: rtl/mmc_cfg_fsm.sv
module mmc_cfg_fsm
    import mmc_clk_pkg::*;
#(
    parameter int unsigned OSC_HZ = 24_000_000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          op,
    input  logic [ID_W-1:0]               id,
    input  logic [RATE_W-1:0]             gpll_hz,
    input  logic [RATE_W-1:0]             req_hz,
    input  logic [CHANS-1:0]              prog_sel,
    input  logic [CHANS-1:0][FIELD_W-1:0] prog_field,
    input  logic                          div_done,
    input  logic [RATE_W-1:0]             div_q,
    output logic                          busy,
    output logic                          done,
    output logic                          err,
    output logic [RATE_W-1:0]             rate,
    output logic [CHANS-1:0]              wr,
    output logic                          wr_sel,
    output logic [FIELD_W-1:0]            wr_field,
    output logic                          div_start,
    output logic [RATE_W-1:0]             div_num,
    output logic [DEN_W-1:0]              div_den
);
    localparam int QW = FIELD_W + 1;
    localparam logic [QW-1:0] QMAX = QW'(MAXDIV);

    cfg_state_e          state_q, state_d;
    logic                chan_q;
    logic                use_osc_q;
    logic [RATE_W-1:0]   tgt_q, req_q, gpll_q, rate_q;
    logic [RATE_W:0]     acc_q, acc_n;
    logic [QW-1:0]       q_q, q_n;
    logic [FIELD_W-1:0]  fld_q;
    logic                hit, id_ok, req_bad;

    assign acc_n   = acc_q + {1'b0, req_q};
    assign q_n     = q_q + 1'b1;
    assign hit     = acc_n >= {1'b0, tgt_q};
    assign id_ok   = id < ID_W'(2 * CHANS);
    assign req_bad = (op == OP_SET) && (req_hz == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = (!id_ok || req_bad) ? ST_REJECT :
                                            (op == OP_SET) ? ST_SEARCH : ST_FETCH;
            ST_SEARCH: if (hit || (q_n == QMAX && use_osc_q)) state_d = ST_APPLY;
            ST_APPLY:  state_d = ST_FETCH;
            ST_FETCH:  state_d = ST_DIVIDE;
            ST_DIVIDE: if (div_done) state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            ST_REJECT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q    <= 1'b0;
            use_osc_q <= 1'b0;
            tgt_q     <= '0;
            req_q     <= '0;
            gpll_q    <= '0;
            rate_q    <= '0;
            acc_q     <= '0;
            q_q       <= '0;
            fld_q     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    chan_q    <= id[1];
                    req_q     <= req_hz;
                    gpll_q    <= gpll_hz;
                    tgt_q     <= gpll_hz >> 1;
                    acc_q     <= '0;
                    q_q       <= '0;
                    use_osc_q <= 1'b0;
                end
                ST_SEARCH: begin
                    if (hit) begin
                        fld_q <= FIELD_W'(q_n - 1'b1);
                    end else if (q_n == QMAX) begin
                        if (!use_osc_q) begin
                            use_osc_q <= 1'b1;
                            tgt_q     <= RATE_W'(OSC_HZ / 2);
                            acc_q     <= '0;
                            q_q       <= '0;
                        end else begin
                            fld_q <= FIELD_W'(MAXDIV - 1);
                        end
                    end else begin
                        acc_q <= acc_n;
                        q_q   <= q_n;
                    end
                end
                ST_DIVIDE: if (div_done) rate_q <= div_q;
                default: ;
            endcase
        end
    end

    always_comb begin
        busy      = state_q != ST_IDLE;
        done      = state_q == ST_REPORT;
        err       = state_q == ST_REJECT;
        rate      = rate_q;
        wr        = '0;
        if (state_q == ST_APPLY) wr[chan_q] = 1'b1;
        wr_sel    = use_osc_q;
        wr_field  = fld_q;
        div_start = state_q == ST_FETCH;
        div_num   = prog_sel[chan_q] ? RATE_W'(OSC_HZ) : gpll_q;
        div_den   = DEN_W'(({2'b00, prog_field[chan_q]} + 1'b1) << 1);
    end

    AST_FALLBACK_AFTER_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(use_osc_q) |-> ($past(q_q) == QMAX - 1'b1)); // R3
    AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr)); // R9
endmodule

// File: rtl/mmc_clkgen.sv
module mmc_clkgen
    import mmc_clk_pkg::*;
#(
    parameter int unsigned OSC_HZ = 24_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gpll_tick,
    input  logic              osc_tick,
    input  logic              cfg_start,
    input  logic              cfg_op,
    input  logic [ID_W-1:0]   cfg_id,
    input  logic [RATE_W-1:0] gpll_hz,
    input  logic [RATE_W-1:0] req_hz,
    output logic              cfg_busy,
    output logic              cfg_done,
    output logic              cfg_err,
    output logic [RATE_W-1:0] rate_hz,
    output logic              emmc_clk,
    output logic              sd_clk
);
    logic [CHANS-1:0]              wr;
    logic                          wr_sel;
    logic [FIELD_W-1:0]            wr_field;
    logic [CHANS-1:0]              prog_sel;
    logic [CHANS-1:0][FIELD_W-1:0] prog_field;
    logic [CHANS-1:0]              ch_clk;
    logic                          div_start, div_done;
    logic [RATE_W-1:0]             div_num, div_q;
    logic [DEN_W-1:0]              div_den;

    mmc_cfg_fsm #(.OSC_HZ(OSC_HZ)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(cfg_start), .op(cfg_op), .id(cfg_id),
        .gpll_hz(gpll_hz), .req_hz(req_hz), .prog_sel(prog_sel),
        .prog_field(prog_field), .div_done(div_done), .div_q(div_q),
        .busy(cfg_busy), .done(cfg_done), .err(cfg_err), .rate(rate_hz),
        .wr(wr), .wr_sel(wr_sel), .wr_field(wr_field), .div_start(div_start),
        .div_num(div_num), .div_den(div_den)
    );

    mmc_long_div #(.NUM_W(RATE_W), .DW(DEN_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start), .num(div_num),
        .den(div_den), .done(div_done), .quot(div_q)
    );

    for (genvar c = 0; c < CHANS; c++) begin : g_chan
        mmc_clk_chan #(.FW(FIELD_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .gpll_tick(gpll_tick), .osc_tick(osc_tick),
            .wr(wr[c]), .wr_sel(wr_sel), .wr_field(wr_field),
            .prog_sel(prog_sel[c]), .prog_field(prog_field[c]),
            .clk_out(ch_clk[c])
        );
    end

    assign emmc_clk = ch_clk[0];
    assign sd_clk   = ch_clk[1];

    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_done && cfg_err)); // R11
    AST_RATE_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rate_hz) |-> cfg_done); // R5
    AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> ($stable(prog_sel) && $stable(prog_field))); // R7
    AST_RESULT_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done || cfg_err) |-> cfg_busy); // R11
endmodule

// File: tb/sim_mmc_clkgen.sv
module sim_mmc_clkgen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gpll_tick = 1'b1;
    logic        osc_tick = 1'b0;
    logic        cfg_start = 1'b0;
    logic        cfg_op = 1'b0;
    logic [2:0]  cfg_id = '0;
    logic [31:0] gpll_hz = '0;
    logic [31:0] req_hz = '0;
    logic        cfg_busy, cfg_done, cfg_err, emmc_clk, sd_clk;
    logic [31:0] rate_hz;

    int     n_chk = 0;
    int     n_err = 0;
    longint cyc = 0;
    int     oscc = 0;

    mmc_clkgen u0 (.*);

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) begin
        oscc     = (oscc + 1) % 4;
        osc_tick = (oscc == 0);
    end

    always @(negedge clk) begin
        if (cyc > 190000) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=%0d expected<190000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic check(input bit ok, input string rq, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic longint exp_rate(input longint g, input longint r);
        longint d, src;
        src = g;
        d = ((g / 2) + r - 1) / r;
        if (d < 1) d = 1;
        if (d > 128) begin
            src = 24000000;
            d = (12000000 + r - 1) / r;
            if (d > 128) d = 128;
        end
        return src / (2 * d);
    endfunction

    task automatic run_cfg(input logic op, input logic [2:0] id, input logic [31:0] g,
                           input logic [31:0] r, output logic [31:0] rt,
                           output logic ok, output logic bad);
        @(negedge clk);
        cfg_op = op; cfg_id = id; gpll_hz = g; req_hz = r; cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        ok = 1'b0; bad = 1'b0; rt = '0;
        for (int i = 0; i < 3000; i++) begin
            if (cfg_done) begin ok = 1'b1; rt = rate_hz; end
            if (cfg_err) bad = 1'b1;
            if (ok || bad) break;
            @(negedge clk);
        end
    endtask

    function automatic logic out_of(input bit sdc);
        return sdc ? sd_clk : emmc_clk;
    endfunction

    task automatic wait_rise(input bit sdc, output longint t);
        logic prev;
        prev = out_of(sdc);
        t = -1;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!prev && out_of(sdc)) begin t = cyc; break; end
            prev = out_of(sdc);
        end
    endtask

    task automatic wait_fall(input bit sdc, output longint t);
        logic prev;
        prev = out_of(sdc);
        t = -1;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (prev && !out_of(sdc)) begin t = cyc; break; end
            prev = out_of(sdc);
        end
    endtask

    task automatic measure(input bit sdc, output longint hi, output longint per);
        longint a, f, b;
        wait_rise(sdc, a);
        wait_rise(sdc, a);
        wait_fall(sdc, f);
        wait_rise(sdc, b);
        hi = f - a;
        per = b - a;
    endtask

    initial begin
        logic [31:0] rt;
        logic ok, bad;
        longint hi, per, r0, r1, r2, e, d;
        longint gl[5];
        longint rl[13];
        int k;

        gl = '{600000000, 594000000, 1188000000, 300000000, 0};
        rl = '{1, 50000, 93750, 93749, 400000, 2343750, 2343749,
               25000000, 52000000, 100000000, 150000000, 400000000, 32'd3000000000};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(!cfg_busy && !cfg_done && !cfg_err, "R10 idle flags", {cfg_busy, cfg_done, cfg_err}, 0);
        run_cfg(1'b1, 3'd0, 32'd600000000, 32'd0, rt, ok, bad);
        check(ok && rt == 12000000, "R10 eMMC reset rate", rt, 12000000);
        run_cfg(1'b1, 3'd3, 32'd600000000, 32'd0, rt, ok, bad);
        check(ok && rt == 12000000, "R10 SD reset rate", rt, 12000000);
        measure(1'b0, hi, per);
        check(per == 8 && hi == 4, "R10 R4 eMMC reset period", per, 8);

        // R11 busy after start
        @(negedge clk);
        cfg_op = 1'b0; cfg_id = 3'd1; gpll_hz = 600000000; req_hz = 2343750; cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        check(cfg_busy == 1'b1, "R11 busy after accept", cfg_busy, 1);
        for (int i = 0; i < 400 && !cfg_done; i++) @(negedge clk);
        check(cfg_done && rate_hz == 2343750, "R2 d=128 via id1", rate_hz, 2343750);

        // R8 boundary: 256-cycle period in flight, reprogram to d=2
        wait_rise(1'b0, r0);
        wait_rise(1'b0, r0);
        run_cfg(1'b0, 3'd0, 32'd600000000, 32'd150000000, rt, ok, bad);
        check(ok && rt == 150000000, "R2 d=2 rate", rt, 150000000);
        wait_rise(1'b0, r1);
        wait_rise(1'b0, r2);
        check(r1 - r0 == 256, "R8 old period completes", r1 - r0, 256);
        check(r2 - r1 == 4, "R8 new period after boundary", r2 - r1, 4);

        // R9 SD unaffected
        measure(1'b1, hi, per);
        check(per == 8, "R9 SD period unchanged", per, 8);

        // R7 rejection
        run_cfg(1'b0, 3'd5, 32'd600000000, 32'd1000000, rt, ok, bad);
        check(bad && !ok, "R7 R1 bad id 5 set", ok, 0);
        run_cfg(1'b1, 3'd6, 32'd600000000, 32'd0, rt, ok, bad);
        check(bad && !ok, "R7 R1 bad id 6 get", ok, 0);
        run_cfg(1'b0, 3'd2, 32'd600000000, 32'd0, rt, ok, bad);
        check(bad && !ok, "R7 zero request", ok, 0);
        run_cfg(1'b1, 3'd1, 32'd600000000, 32'd0, rt, ok, bad);
        check(ok && rt == 150000000, "R7 R6 eMMC kept", rt, 150000000);
        run_cfg(1'b1, 3'd2, 32'd600000000, 32'd0, rt, ok, bad);
        check(ok && rt == 12000000, "R7 R9 SD kept", rt, 12000000);

        // R11 start during busy ignored (long clamp search)
        @(negedge clk);
        cfg_op = 1'b0; cfg_id = 3'd2; gpll_hz = 600000000; req_hz = 1; cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        repeat (20) @(negedge clk);
        cfg_id = 3'd7; cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        ok = 1'b0; bad = 1'b0;
        for (int i = 0; i < 600 && !ok; i++) begin
            if (cfg_err) bad = 1'b1;
            if (cfg_done) begin ok = 1'b1; rt = rate_hz; end
            else @(negedge clk);
        end
        check(ok && !bad && rt == 93750, "R11 R3 ignore start while busy", rt, 93750);
        repeat (3) @(negedge clk);
        check(!cfg_err && !cfg_busy, "R11 no late result", cfg_err, 0);

        // Sweep R2 R3 R5 R6 R1
        k = 0;
        foreach (gl[gi]) begin
            foreach (rl[ri]) begin
                e = exp_rate(gl[gi], rl[ri]);
                run_cfg(1'b0, 3'(k % 4), 32'(gl[gi]), 32'(rl[ri]), rt, ok, bad);
                check(ok && !bad && rt == e, "R2 R3 R5 set sweep", rt, e);
                run_cfg(1'b1, 3'((k + 1) % 2 + (k % 4 >= 2 ? 2 : 0)), 32'(gl[gi]), 32'd0, rt, ok, bad);
                check(ok && rt == e, "R1 R6 get via sibling id", rt, e);
                k++;
            end
        end

        // R4 period/duty sweep, PLL source with gpll_hz=256 so d=ceil(128/r)
        foreach (rl[ri]) begin
            if (ri < 10) begin
                longint rr;
                rr = (ri == 0) ? 1 : (ri == 1) ? 2 : (ri == 2) ? 3 : (ri == 3) ? 5 :
                     (ri == 4) ? 8 : (ri == 5) ? 16 : (ri == 6) ? 43 : (ri == 7) ? 64 :
                     (ri == 8) ? 128 : 200;
                d = (128 + rr - 1) / rr;
                run_cfg(1'b0, 3'd0, 32'd256, 32'(rr), rt, ok, bad);
                measure(1'b0, hi, per);
                check(per == 2 * d && hi == d, "R4 PLL period", per, 2 * d);
            end
        end
        // R3 R4 oscillator source period (osc tick every 4 cycles, d=120)
        run_cfg(1'b0, 3'd3, 32'd600000000, 32'd100000, rt, ok, bad);
        check(ok && rt == 100000, "R3 osc rate", rt, 100000);
        measure(1'b1, hi, per);
        check(per == 960 && hi == 480, "R3 R4 osc period", per, 960);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule